// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block produces the memory word addresses for a block transfer between a register file and memory. A request gives a base address, a 16-bit mask of the registers taking part, a load/store flag, a writeback flag and a two-bit addressing mode. After a start pulse the block offers one transfer per cycle on a valid/ready handshake. Each transfer carries a word address and the index of the register to move. When the handshake accepts the final transfer, the block raises a one-cycle completion pulse. If writeback was requested, the new base value comes with that pulse.

The mode code works as follows. Bit 1 selects the direction: 0 walks addresses up, 1 walks them down. Bit 0 selects when the step is applied: 0 steps after each transfer, 1 steps before it. The four codes are therefore 0 for increment-after, 1 for increment-before, 2 for decrement-after and 3 for decrement-before. Decrement modes start at the base and walk downward. They visit registers from the highest index to the lowest, so the lowest address is never computed in advance. The memory, the register file and the data movement belong to the surrounding design.

Top module: `lsm_addr_seq`

## Requirements
- R1: For mode codes 0 and 1 the transfers name the set bits of the register mask in ascending index order, one transfer per set bit.
- R2: For mode codes 2 and 3 the transfers name the set bits of the register mask in descending index order, one transfer per set bit.
- R3: The first transfer address depends on the mode, where A is the base with bits [1:0] cleared. Code 0 gives A. Code 1 gives A+4. Code 2 gives A. Code 3 gives A-4. All arithmetic is modulo 2^32.
- R4: Each following address differs from the previous one by exactly 4: upward for codes 0 and 1, downward for codes 2 and 3. Bits [1:0] of every transfer address are zero.
- R5: The writeback value is defined from L, the address of the last transfer. Code 0 gives L+4. Code 1 gives L. Code 2 gives L-4. Code 3 gives L. With an all-zero mask the writeback value is A. `wb_valid` is high exactly when `done` is high and the writeback flag of that request was 1.
- R6: `done` is high for exactly one cycle. That cycle is the one after the handshake accepts the transfer flagged by `xfer_last`. `xfer_last` is high only on the final transfer, and `xfer_valid` is low in the `done` cycle.
- R7: A start with an all-zero mask produces no transfer, and `done` is high in the cycle after the start.
- R8: A start that arrives while `xfer_valid` is high is ignored. This includes the cycle in which the final transfer is accepted. The running sequence continues unchanged.
- R9: `xfer_load` repeats the load/store flag of the request on every transfer. Loads and stores produce identical address and register sequences.
- R10: While `xfer_valid` is high and `xfer_ready` is low, the address, register index and last flag hold their values.
- R11: After reset, `xfer_valid`, `done` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| base | input | 32 | Base address of the request |
| reg_mask | input | 16 | Participating registers, bit i = register i |
| is_load | input | 1 | 1 = load, 0 = store |
| wb_en | input | 1 | Report a writeback value on completion |
| mode | input | 2 | Bit 1 = decrement, bit 0 = step before transfer |
| xfer_valid | output | 1 | A transfer is offered |
| xfer_ready | input | 1 | The transfer is accepted this cycle |
| xfer_addr | output | 32 | Word address of the offered transfer |
| xfer_reg | output | 4 | Register index of the offered transfer |
| xfer_load | output | 1 | Load/store flag of the offered transfer |
| xfer_last | output | 1 | The offered transfer is the final one |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback value is valid (with done) |
| wb_value | output | 32 | New base value |

## Verification
Two events can land in the same cycle: a new start, and the acceptance of the final transfer that ends the current sequence. The bench raises `start` at random points while transfers are pending, including the acceptance cycle of the final transfer. Each such start carries a different mask, base and mode. The check is that the transfers, the `done` pulse and the writeback value still match the model of the original request. A second overlap is also exercised: a start in the cycle that `done` is high is accepted normally, and the bench checks that the next sequence begins one cycle later.

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [NREG-1:0]   reg_mask,
  input  logic              is_load,
  input  logic              wb_en,
  input  logic [1:0]        mode,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [IDX_W-1:0]  xfer_reg,
  output logic              xfer_load,
  output logic              xfer_last,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_value
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic              busy_q, dec_q, before_q, load_q, wb_q;
  logic              done_q, wbv_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q, wbval_q;

  logic [IDX_W-1:0]  cur_idx;
  logic [NREG-1:0]   cur_bit;
  logic [ADDR_W-1:0] abase, first_addr, next_addr;
  logic              start_ok, fire, last;

  always_comb begin
    cur_idx = '0;
    if (dec_q) begin
      for (int i = 0; i < NREG; i++)
        if (mask_q[i]) cur_idx = IDX_W'(i);
    end else begin
      for (int i = NREG - 1; i >= 0; i--)
        if (mask_q[i]) cur_idx = IDX_W'(i);
    end
  end

  assign cur_bit    = NREG'(1) << cur_idx;
  assign last       = (mask_q & ~cur_bit) == '0;
  assign start_ok   = start & ~busy_q;
  assign fire       = busy_q & xfer_ready;
  assign abase      = {base[ADDR_W-1:2], 2'b00};
  assign first_addr = !mode[0] ? abase : (mode[1] ? abase - STEP_V : abase + STEP_V);
  assign next_addr  = dec_q ? addr_q - STEP_V : addr_q + STEP_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dec_q    <= 1'b0;
      before_q <= 1'b0;
      load_q   <= 1'b0;
      wb_q     <= 1'b0;
      done_q   <= 1'b0;
      wbv_q    <= 1'b0;
      mask_q   <= '0;
      addr_q   <= '0;
      wbval_q  <= '0;
    end else begin
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      if (start_ok) begin
        busy_q   <= |reg_mask;
        mask_q   <= reg_mask;
        addr_q   <= first_addr;
        dec_q    <= mode[1];
        before_q <= mode[0];
        load_q   <= is_load;
        wb_q     <= wb_en;
        wbval_q  <= abase;
        done_q   <= ~|reg_mask;
        wbv_q    <= wb_en & ~|reg_mask;
      end else if (fire) begin
        mask_q <= mask_q & ~cur_bit;
        addr_q <= next_addr;
        if (last) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          wbv_q   <= wb_q;
          wbval_q <= before_q ? addr_q : next_addr;
        end
      end
    end
  end

  assign xfer_valid = busy_q;
  assign xfer_addr  = addr_q;
  assign xfer_reg   = cur_idx;
  assign xfer_load  = load_q;
  assign xfer_last  = busy_q & last;
  assign done       = done_q;
  assign wb_valid   = wbv_q;
  assign wb_value   = wbval_q;

endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [NREG-1:0]   reg_mask,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [IDX_W-1:0]  xfer_reg,
  input logic              xfer_last,
  input logic              done,
  input logic              wb_valid
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_reg) && $stable(xfer_last));

  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_addr[1:0] == 2'b00);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready && !xfer_last |=>
      xfer_valid && (xfer_addr == $past(xfer_addr) + ADDR_W'(4) || xfer_addr == $past(xfer_addr) - ADDR_W'(4)));

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready && xfer_last |=> done && !xfer_valid);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !xfer_valid && reg_mask == '0 |=> done && !xfer_valid);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && start && !(xfer_ready && xfer_last) |=> xfer_valid && !done);

  p_wb_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
  .xfer_reg(xfer_reg), .xfer_last(xfer_last), .done(done), .wb_valid(wb_valid)
);

// File: tb/lsm_addr_seq_tb.sv
module lsm_addr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0, is_load = 0, wb_en = 0, xfer_ready = 0;
  logic [31:0] base = 0;
  logic [15:0] reg_mask = 0;
  logic [1:0]  mode = 0;
  logic        xfer_valid, xfer_load, xfer_last, done, wb_valid;
  logic [31:0] xfer_addr, wb_value;
  logic [3:0]  xfer_reg;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsm_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .reg_mask(reg_mask),
    .is_load(is_load), .wb_en(wb_en), .mode(mode), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
    .xfer_load(xfer_load), .xfer_last(xfer_last), .done(done),
    .wb_valid(wb_valid), .wb_value(wb_value)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                         input bit ld, input bit wb, input int ready_pct, input bit noise);
    int idx[16];
    int n = 0;
    logic [31:0] a, step, wexp;
    if (md[1]) begin
      for (int i = 15; i >= 0; i--) if (m[i]) begin idx[n] = i; n++; end
    end else begin
      for (int i = 0; i < 16; i++) if (m[i]) begin idx[n] = i; n++; end
    end
    step = md[1] ? 32'hFFFF_FFFC : 32'd4;
    a = {b[31:2], 2'b00};
    wexp = a;
    if (md[0]) a = a + step;
    @(negedge clk);
    start = 1; base = b; reg_mask = m; mode = md; is_load = ld; wb_en = wb;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < n; ) begin
      chk(xfer_valid === 1'b1, "R6 valid during sequence", {31'b0, xfer_valid}, 32'd1);
      chk(xfer_addr === a, md[1] ? "R4/R3 addr (dec)" : "R4/R3 addr (inc)", xfer_addr, a);
      chk(xfer_reg === 4'(idx[k]), md[1] ? "R2 reg order" : "R1 reg order", {28'b0, xfer_reg}, idx[k]);
      chk(xfer_last === (k == n - 1), "R6 last flag", {31'b0, xfer_last}, {31'b0, k == n - 1});
      chk(xfer_load === ld, "R9 load flag", {31'b0, xfer_load}, {31'b0, ld});
      chk(done === 1'b0, "R8 no done while busy", {31'b0, done}, 0);
      xfer_ready = ($urandom_range(99) < 32'(ready_pct));
      if (noise && $urandom_range(3) == 0) begin
        start = 1; reg_mask = 16'h0000; base = $urandom; mode = 2'(~md); wb_en = ~wb; is_load = ~ld;
      end else start = 0;
      if (xfer_ready) begin
        if (k == n - 1) wexp = md[0] ? a : a + step;
        a = a + step;
        k++;
      end
      @(negedge clk);
    end
    start = 0; xfer_ready = 0;
    chk(done === 1'b1, n == 0 ? "R7 empty done" : "R6 done after last", {31'b0, done}, 1);
    chk(xfer_valid === 1'b0, n == 0 ? "R7 no transfer" : "R6 idle at done", {31'b0, xfer_valid}, 0);
    chk(wb_valid === wb, "R5 wb_valid", {31'b0, wb_valid}, {31'b0, wb});
    if (wb) chk(wb_value === wexp, "R5 wb value", wb_value, wexp);
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", {31'b0, done}, 0);
    chk(xfer_valid === 1'b0, "R8 ignored start", {31'b0, xfer_valid}, 0);
  endtask

  initial begin
    void'($urandom(32'h1A5E_0D17));
    repeat (3) @(negedge clk);
    chk(xfer_valid === 1'b0 && done === 1'b0 && wb_valid === 1'b0, "R11 reset state",
        {29'b0, xfer_valid, done, wb_valid}, 0);
    rst_n = 1;
    for (int md = 0; md < 4; md++) begin
      run_seq(32'h4000_0010, 16'h000E, 2'(md), 1, 1, 100, 0);
      run_seq(32'h4000_0010, 16'h000E, 2'(md), 0, 1, 100, 0);
    end
    run_seq(32'h1234_5678, 16'h0000, 2'd0, 1, 1, 100, 0);
    run_seq(32'h1234_5678, 16'h0000, 2'd3, 0, 0, 100, 0);
    run_seq(32'h8000_0000, 16'hFFFF, 2'd0, 1, 1, 100, 0);
    run_seq(32'h8000_0040, 16'hFFFF, 2'd3, 0, 1, 50, 1);
    run_seq(32'h4000_0013, 16'h8001, 2'd1, 1, 1, 60, 1);
    run_seq(32'h0000_0000, 16'h8000, 2'd3, 0, 1, 100, 0);
    run_seq(32'hFFFF_FFFC, 16'h0001, 2'd1, 1, 1, 100, 0);
    run_seq(32'h0000_0002, 16'h0003, 2'd2, 1, 1, 40, 1);
    for (int t = 0; t < 60; t++)
      run_seq($urandom, 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 30 + $urandom_range(70), 1);
    // back-to-back: start in the done cycle is accepted
    @(negedge clk);
    start = 1; base = 32'h100; reg_mask = 16'h0000; mode = 0; wb_en = 1;
    @(negedge clk);
    reg_mask = 16'h0004; base = 32'h200;
    chk(done === 1'b1, "R7 empty done", {31'b0, done}, 1);
    @(negedge clk);
    start = 0;
    chk(xfer_valid === 1'b1 && xfer_reg === 4'd2 && xfer_addr === 32'h200, "R3 start in done cycle",
        xfer_addr, 32'h200);
    xfer_ready = 1;
    @(negedge clk);
    xfer_ready = 0;
    chk(wb_value === 32'h204, "R5 wb after restart", wb_value, 32'h204);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule